// File: doc/BRIEF.md
# SPI-mode command response token formatter

This block builds the response that a storage device returns to its host after every command on a byte-serial SPI link. A command sequencer hands it the index of the command just handled, or a notice that a requested read cannot deliver data. The formatter picks the token shape and streams it out as bytes over a valid/ready handshake, most significant byte first. A plain command gets a one-byte status token. The status-query command gets that byte followed by an extended status byte. The configuration-register query gets that byte followed by the 32-bit operating-condition word. A failed read gets a one-byte error token in place of its data block.

Error conditions reach the block as one-cycle event pulses. Each pulse is held in a sticky flag until a token that carries that flag has been fully accepted by the consumer. Only then is the flag cleared. Flags that the token did not carry, and events that arrive while a token is in flight, stay pending. The idle and lock indications are levels and are sampled when a request is accepted.

Top module: `rsp_token_fmt`

## Requirements
- R1: Every accepted request produces a token, and no command index is refused. A request is accepted on a clock edge where `req_ready` is high and `cmd_valid` or `rdfail_valid` is high. `tok_valid` is high in the following cycle, and `req_ready` stays low while a token is outstanding.
- R2: Any command index other than the status and configuration queries returns one status byte. Bit 7 is 0, bit 6 is the parameter flag, bit 5 the address flag, bit 4 the erase-sequence flag, bit 3 the CRC flag, bit 2 the illegal-command flag, bit 1 the erase-reset flag and bit 0 `in_idle` as sampled at acceptance.
- R3: Command index 13 returns two bytes. The first is the R2 status byte. The second holds out-of-range (bit 7), erase-parameter (6), write-protect violation (5), ECC failure (4), internal controller error (3), general error (2), write-protect skip (1) and `card_locked` (0).
- R4: Command index 58 returns five bytes: the R2 status byte, then `ocr_word` from bits 31:24 down to bits 7:0.
- R5: An accepted `rdfail_valid` returns one error byte. Bits 7:4 are 0, bit 3 is out-of-range, bit 2 is ECC failure, bit 1 is internal controller error and bit 0 is general error.
- R6: A 1 on `flag_set` bit i sets sticky flag i. The positions are: 0 erase-reset, 1 illegal command, 2 CRC, 3 erase sequence, 4 address, 5 parameter, 6 write-protect skip, 7 general error, 8 controller error, 9 ECC failure, 10 write-protect violation, 11 erase parameter, 12 out-of-range.
- R7: A flag is cleared once the final byte of a token that reported it set has been handshaken. Flags that the token does not carry remain set.
- R8: A flag event that arrives while a token is in flight is not lost. It is reported by a later token.
- R9: While `tok_valid` is high and `tok_ready` is low, `tok_data` and `tok_last` hold their values.
- R10: When `cmd_valid` and `rdfail_valid` are high together, the command is served first. A held `rdfail_valid` is served after that token completes.
- R11: After reset, `tok_valid` is 0, `req_ready` is 1 and every sticky flag is clear.
- R12: `tok_last` is high exactly on the final byte of each token.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command response is requested |
| cmd_idx | input | 6 | Index of the command being answered |
| rdfail_valid | input | 1 | A read failed; send the error token |
| req_ready | output | 1 | Formatter can accept a request |
| flag_set | input | 13 | Error event pulses, one bit per sticky flag |
| in_idle | input | 1 | Device is in its idle state |
| card_locked | input | 1 | Device is password locked |
| ocr_word | input | 32 | Operating-condition word for the configuration query |
| tok_data | output | 8 | Current token byte |
| tok_valid | output | 1 | `tok_data` is valid |
| tok_ready | input | 1 | Consumer takes the byte |
| tok_last | output | 1 | Current byte is the last of its token |

## Verification
The hardest case to reach is a flag event that lands while a token is still streaming. This must be distinguished from one that was reported, so that clearing touches only what went out. The bench holds `tok_ready` low on a two-byte token and pulses a flag in mid-token, then reads the flag back through the next token. It also sets a flag that one token shape cannot carry, runs that shape, and then drains the flag through a shape that does carry it. This shows the first token left it pending.

// File: rtl/rsp_fmt_pkg.sv
package rsp_fmt_pkg;

  localparam int unsigned FLAG_W = 13;

  localparam int unsigned FL_ERST   = 0;
  localparam int unsigned FL_ILL    = 1;
  localparam int unsigned FL_CRC    = 2;
  localparam int unsigned FL_ESEQ   = 3;
  localparam int unsigned FL_ADDR   = 4;
  localparam int unsigned FL_PARM   = 5;
  localparam int unsigned FL_WPSKIP = 6;
  localparam int unsigned FL_GEN    = 7;
  localparam int unsigned FL_CC     = 8;
  localparam int unsigned FL_ECC    = 9;
  localparam int unsigned FL_WPV    = 10;
  localparam int unsigned FL_EPRM   = 11;
  localparam int unsigned FL_OOR    = 12;

  typedef enum logic [1:0] {
    TK_STAT  = 2'd0,
    TK_XSTAT = 2'd1,
    TK_COND  = 2'd2,
    TK_DERR  = 2'd3
  } tok_kind_e;

  // flags carried by the common status byte
  localparam logic [FLAG_W-1:0] MASK_STAT =
    (FLAG_W'(1) << FL_ERST) | (FLAG_W'(1) << FL_ILL)  | (FLAG_W'(1) << FL_CRC) |
    (FLAG_W'(1) << FL_ESEQ) | (FLAG_W'(1) << FL_ADDR) | (FLAG_W'(1) << FL_PARM);

  // flags carried by the data error byte
  localparam logic [FLAG_W-1:0] MASK_DERR =
    (FLAG_W'(1) << FL_GEN) | (FLAG_W'(1) << FL_CC) |
    (FLAG_W'(1) << FL_ECC) | (FLAG_W'(1) << FL_OOR);

  localparam logic [FLAG_W-1:0] MASK_ALL = {FLAG_W{1'b1}};

endpackage

// File: rtl/rsp_flag_bank.sv
module rsp_flag_bank
  import rsp_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              clr_en_i,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] flags_o
);

  logic [FLAG_W-1:0] flags_q, flags_d;

  // a set arriving in the clearing cycle wins over the clear
  always_comb begin
    flags_d = flags_q;
    if (clr_en_i) flags_d = flags_d & ~clr_i;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/rsp_token_pack.sv
module rsp_token_pack
  import rsp_fmt_pkg::*;
#(
  parameter int unsigned OCR_W = 32,
  localparam int unsigned WORD_W = 8 + OCR_W,
  localparam int unsigned LEN_W  = $clog2(WORD_W / 8 + 1)
)(
  input  tok_kind_e         kind_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              idle_i,
  input  logic              locked_i,
  input  logic [OCR_W-1:0]  ocr_i,
  output logic [WORD_W-1:0] word_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [FLAG_W-1:0] clr_o
);

  logic [7:0] stat_b, xstat_b, derr_b;

  always_comb begin
    stat_b  = {1'b0, flags_i[FL_PARM], flags_i[FL_ADDR], flags_i[FL_ESEQ],
               flags_i[FL_CRC], flags_i[FL_ILL], flags_i[FL_ERST], idle_i};
    xstat_b = {flags_i[FL_OOR], flags_i[FL_EPRM], flags_i[FL_WPV], flags_i[FL_ECC],
               flags_i[FL_CC], flags_i[FL_GEN], flags_i[FL_WPSKIP], locked_i};
    derr_b  = {4'b0000, flags_i[FL_OOR], flags_i[FL_ECC], flags_i[FL_CC], flags_i[FL_GEN]};
  end

  always_comb begin
    unique case (kind_i)
      TK_XSTAT: begin
        word_o = {stat_b, xstat_b, {(WORD_W-16){1'b0}}};
        len_o  = LEN_W'(2);
        clr_o  = MASK_ALL & flags_i;
      end
      TK_COND: begin
        word_o = {stat_b, ocr_i};
        len_o  = LEN_W'(WORD_W / 8);
        clr_o  = MASK_STAT & flags_i;
      end
      TK_DERR: begin
        word_o = {derr_b, {(WORD_W-8){1'b0}}};
        len_o  = LEN_W'(1);
        clr_o  = MASK_DERR & flags_i;
      end
      default: begin
        word_o = {stat_b, {(WORD_W-8){1'b0}}};
        len_o  = LEN_W'(1);
        clr_o  = MASK_STAT & flags_i;
      end
    endcase
  end

endmodule

// File: rtl/rsp_byte_shifter.sv
module rsp_byte_shifter #(
  parameter int unsigned MAX_BYTES = 5,
  localparam int unsigned WORD_W = 8 * MAX_BYTES,
  localparam int unsigned LEN_W  = $clog2(MAX_BYTES + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              ready_i,
  output logic [7:0]        data_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              done_o
);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              step;

  assign step   = act_q & ready_i;
  assign last_o = act_q & (cnt_q == LEN_W'(1));
  assign done_o = step & last_o;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (load_i) begin
      sh_d  = word_i;
      cnt_d = len_i;
      act_d = 1'b1;
    end else if (step) begin
      sh_d  = sh_q << 8;
      cnt_d = cnt_q - LEN_W'(1);
      if (cnt_q == LEN_W'(1)) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign data_o  = sh_q[WORD_W-1 -: 8];
  assign valid_o = act_q;

endmodule

// File: rtl/rsp_token_fmt.sv
module rsp_token_fmt
  import rsp_fmt_pkg::*;
#(
  parameter int unsigned CMD_W      = 6,
  parameter int unsigned OCR_W      = 32,
  parameter int unsigned STATUS_CMD = 13,
  parameter int unsigned COND_CMD   = 58
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_idx,
  input  logic              rdfail_valid,
  output logic              req_ready,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic              in_idle,
  input  logic              card_locked,
  input  logic [OCR_W-1:0]  ocr_word,
  output logic [7:0]        tok_data,
  output logic              tok_valid,
  input  logic              tok_ready,
  output logic              tok_last
);

  localparam int unsigned MAX_BYTES = 1 + OCR_W / 8;
  localparam int unsigned WORD_W    = 8 * MAX_BYTES;
  localparam int unsigned LEN_W     = $clog2(MAX_BYTES + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              accept, done;
  tok_kind_e         kind;
  logic [FLAG_W-1:0] flags, clr_now;
  logic [FLAG_W-1:0] clr_q, clr_d;
  logic [WORD_W-1:0] word;
  logic [LEN_W-1:0]  len;

  assign req_ready = rst_int_n & ~tok_valid;
  assign accept    = req_ready & (cmd_valid | rdfail_valid);

  // commands take precedence over a pending read failure
  always_comb begin
    if (!cmd_valid)                               kind = TK_DERR;
    else if (cmd_idx == CMD_W'(STATUS_CMD))       kind = TK_XSTAT;
    else if (cmd_idx == CMD_W'(COND_CMD))         kind = TK_COND;
    else                                          kind = TK_STAT;
  end

  rsp_flag_bank u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_i    (flag_set),
    .clr_en_i (done),
    .clr_i    (clr_q),
    .flags_o  (flags)
  );

  rsp_token_pack #(.OCR_W(OCR_W)) u_pack (
    .kind_i   (kind),
    .flags_i  (flags),
    .idle_i   (in_idle),
    .locked_i (card_locked),
    .ocr_i    (ocr_word),
    .word_o   (word),
    .len_o    (len),
    .clr_o    (clr_now)
  );

  rsp_byte_shifter #(.MAX_BYTES(MAX_BYTES)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (accept),
    .word_i  (word),
    .len_i   (len),
    .ready_i (tok_ready),
    .data_o  (tok_data),
    .valid_o (tok_valid),
    .last_o  (tok_last),
    .done_o  (done)
  );

  // remember exactly which flags went out in this token
  always_comb begin
    clr_d = clr_q;
    if (accept) clr_d = clr_now;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) clr_q <= '0;
    else            clr_q <= clr_d;
  end

endmodule

// File: rtl/rsp_token_fmt_chk.sv
module rsp_token_fmt_chk #(
  parameter int unsigned CMD_W      = 6,
  parameter int unsigned STATUS_CMD = 13,
  parameter int unsigned COND_CMD   = 58,
  parameter int unsigned OCR_W      = 32
)(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_idx,
  input logic             rdfail_valid,
  input logic             req_ready,
  input logic [7:0]       tok_data,
  input logic             tok_valid,
  input logic             tok_ready,
  input logic             tok_last
);

  logic       ck_first, ck_isrd;
  logic [3:0] ck_cnt, ck_len;
  logic       ck_acc;

  assign ck_acc = req_ready & (cmd_valid | rdfail_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_first <= 1'b0;
      ck_isrd  <= 1'b0;
      ck_cnt   <= '0;
      ck_len   <= '0;
    end else if (ck_acc) begin
      ck_first <= 1'b1;
      ck_isrd  <= ~cmd_valid;
      ck_cnt   <= '0;
      if (!cmd_valid)                          ck_len <= 4'd1;
      else if (cmd_idx == CMD_W'(STATUS_CMD))  ck_len <= 4'd2;
      else if (cmd_idx == CMD_W'(COND_CMD))    ck_len <= 4'(1 + OCR_W / 8);
      else                                     ck_len <= 4'd1;
    end else if (tok_valid && tok_ready) begin
      ck_first <= 1'b0;
      ck_cnt   <= ck_cnt + 4'd1;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ck_acc |=> tok_valid); // R1
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |-> !req_ready); // R1
  AST_STAT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && ck_first && !ck_isrd) |-> !tok_data[7]); // R2
  AST_DERR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && ck_first && ck_isrd) |-> (tok_data[7:4] == 4'h0)); // R5
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_data) && $stable(tok_last))); // R9
  AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && rdfail_valid && req_ready) |=> !ck_isrd); // R10
  AST_LAST_ON_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |-> (tok_last == ((ck_cnt + 4'd1) == ck_len))); // R12

endmodule

bind rsp_token_fmt rsp_token_fmt_chk #(
  .CMD_W(CMD_W), .STATUS_CMD(STATUS_CMD), .COND_CMD(COND_CMD), .OCR_W(OCR_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
  .rdfail_valid(rdfail_valid), .req_ready(req_ready), .tok_data(tok_data),
  .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_last(tok_last)
);

// File: tb/tb_rsp_token_fmt.sv
module tb_rsp_token_fmt;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic        rdfail_valid = 1'b0;
  logic        req_ready;
  logic [12:0] flag_set = '0;
  logic        in_idle = 1'b0;
  logic        card_locked = 1'b0;
  logic [31:0] ocr_word = '0;
  logic [7:0]  tok_data;
  logic        tok_valid;
  logic        tok_ready = 1'b1;
  logic        tok_last;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rsp_token_fmt dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
    .rdfail_valid(rdfail_valid), .req_ready(req_ready), .flag_set(flag_set),
    .in_idle(in_idle), .card_locked(card_locked), .ocr_word(ocr_word),
    .tok_data(tok_data), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_last(tok_last)
  );

  typedef struct packed {
    logic        isrd;
    logic [5:0]  idx;
    logic [12:0] set;
    logic        idle;
    logic        lock;
    logic [31:0] ocr;
    logic [2:0]  len;
    logic [39:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 6'd17, 13'h0000, 1'b1, 1'b0, 32'h0,        3'd1, 40'h01_00000000}, // R2
    '{1'b0, 6'd0,  13'h000A, 1'b0, 1'b0, 32'h0,        3'd1, 40'h14_00000000}, // R2 R6
    '{1'b0, 6'd13, 13'h1084, 1'b0, 1'b1, 32'h0,        3'd2, 40'h08_85000000}, // R3
    '{1'b0, 6'd58, 13'h0020, 1'b1, 1'b0, 32'h80FF8000, 3'd5, 40'h41_80FF8000}, // R4
    '{1'b1, 6'd0,  13'h0300, 1'b0, 1'b0, 32'h0,        3'd1, 40'h06_00000000}, // R5
    '{1'b0, 6'd24, 13'h1010, 1'b0, 1'b0, 32'h0,        3'd1, 40'h20_00000000}, // R7 oor stays
    '{1'b1, 6'd0,  13'h0000, 1'b0, 1'b0, 32'h0,        3'd1, 40'h08_00000000}, // R7 drained
    '{1'b0, 6'd13, 13'h0C41, 1'b1, 1'b0, 32'h0,        3'd2, 40'h03_62000000}, // R3
    '{1'b0, 6'd63, 13'h0000, 1'b0, 1'b0, 32'h0,        3'd1, 40'h00_00000000}, // R1 any index
    '{1'b0, 6'd13, 13'h0000, 1'b1, 1'b1, 32'h0,        3'd2, 40'h01_01000000}  // R7 all clear
  };

  task automatic check(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one request (flags already staged), then collect len bytes
  task automatic issue(input bit isrd, input logic [5:0] idx);
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready before request", 40'(req_ready), 40'd1);
    if (isrd) rdfail_valid = 1'b1;
    else begin cmd_valid = 1'b1; cmd_idx = idx; end
    @(negedge clk);
    cmd_valid = 1'b0;
    rdfail_valid = 1'b0;
    check(tok_valid == 1'b1, "R1 token follows request", 40'(tok_valid), 40'd1);
    check(req_ready == 1'b0, "R1 busy while token out", 40'(req_ready), 40'd0);
  endtask

  task automatic collect(input int len, input logic [39:0] exp, input string req);
    for (int i = 0; i < len; i++) begin
      check(tok_valid == 1'b1, req, 40'(tok_valid), 40'd1);
      check(tok_data == exp[39-8*i -: 8], req, 40'(tok_data), 40'(exp[39-8*i -: 8]));
      check(tok_last == (i == len - 1), "R12 last marker", 40'(tok_last), 40'(i == len - 1));
      @(negedge clk);
    end
    check(tok_valid == 1'b0, "R12 token ends", 40'(tok_valid), 40'd0);
  endtask

  task automatic stage(input logic [12:0] s, input logic idle, input logic lock,
                       input logic [31:0] ocr);
    @(negedge clk);
    flag_set = s; in_idle = idle; card_locked = lock; ocr_word = ocr;
    @(negedge clk);
    flag_set = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(tok_valid == 1'b0, "R11 no token in reset", 40'(tok_valid), 40'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tok_valid == 1'b0, "R11 no token after reset", 40'(tok_valid), 40'd0);
    check(req_ready == 1'b1, "R11 ready after reset", 40'(req_ready), 40'd1);
    issue(1'b0, 6'd13);
    collect(2, 40'h00_00000000, "R11 flags clear after reset");

    // table walk
    for (int v = 0; v < NV; v++) begin
      stage(TBL[v].set, TBL[v].idle, TBL[v].lock, TBL[v].ocr);
      issue(TBL[v].isrd, TBL[v].idx);
      collect(int'(TBL[v].len), TBL[v].exp, $sformatf("R2-5 table vector %0d", v));
    end

    // R9: backpressure on the five-byte token
    stage(13'h0000, 1'b0, 1'b0, 32'hA1B2C3D4);
    tok_ready = 1'b0;
    issue(1'b0, 6'd58);
    repeat (3) begin
      check(tok_data == 8'h00, "R9 first byte held", 40'(tok_data), 40'h00);
      check(tok_valid == 1'b1, "R9 valid held", 40'(tok_valid), 40'd1);
      check(req_ready == 1'b0, "R1 no accept while stalled", 40'(req_ready), 40'd0);
      @(negedge clk);
    end
    tok_ready = 1'b1;
    collect(5, 40'h00_A1B2C3D4, "R4 after stall");

    // R8: event during an in-flight token survives
    stage(13'h0000, 1'b0, 1'b0, 32'h0);
    tok_ready = 1'b0;
    issue(1'b0, 6'd13);
    flag_set = 13'h0002; // illegal-command event mid-token
    @(negedge clk);
    flag_set = '0;
    tok_ready = 1'b1;
    collect(2, 40'h00_00000000, "R8 in-flight token unaffected");
    issue(1'b0, 6'd17);
    collect(1, 40'h04_00000000, "R8 late event reported");
    issue(1'b0, 6'd17);
    collect(1, 40'h00_00000000, "R7 late event cleared");

    // R10: simultaneous command and read failure
    stage(13'h0200, 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_idx = 6'd17; rdfail_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(tok_data == 8'h00, "R10 command served first", 40'(tok_data), 40'h00);
    @(negedge clk);
    @(negedge clk);
    rdfail_valid = 1'b0;
    check(tok_valid == 1'b1, "R10 read failure served next", 40'(tok_valid), 40'd1);
    check(tok_data == 8'h04, "R10 error token content", 40'(tok_data), 40'h04);
    @(negedge clk);
    check(tok_valid == 1'b0, "R10 no extra token", 40'(tok_valid), 40'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule